// File: doc/BRIEF.md
# Light-Load Conduction Mode Controller

This block chooses, once per switching period, whether a converter phase runs in continuous conduction (CCM) or discontinuous conduction (DCM). A single-cycle strobe marks each switching period. With it come two comparator flags: one says the inductor valley current was under the entry level during that period, and the other says it was over the exit level.

Moving into DCM is slow on purpose. The phase must see a long unbroken run of low-valley periods, and that only counts while a static configuration bit allows DCM. Moving back to CCM is fast: one period with the exit flag set is enough. The sequencer can also hold the phase in CCM at any time, for example while switching is stopped or during soft-start. This hold also clears the run count.

The block also produces a 2-bit code. The code tells the comparator which entry level to use, and that level depends on the configured overcurrent setting.

Top module: `dcm_mode_ctrl`

## Requirements
- R1: After reset, `mode_dcm` is 0 and the run count is zero. From that state, entering DCM takes a full run of `ENTRY_CYCLES` (default 48) qualifying strobes.
- R2: In CCM with `dcm_allow` high, the clock edge that samples the 48th consecutive strobe with `below_entry` high sets `mode_dcm` to 1. After 47 such strobes, `mode_dcm` is still 0.
- R3: In CCM, a strobe with `below_entry` low restarts the run. A full 48 further qualifying strobes are then needed.
- R4: Clock edges without `cyc_stb` neither advance the run nor reset it.
- R5: In DCM, the edge that samples a strobe with `above_exit` high returns `mode_dcm` to 0. A high `above_exit` without a strobe has no effect.
- R6: Every return to CCM clears the run. The run count saturates at `ENTRY_CYCLES` and never goes past it.
- R7: A strobe sampled with `dcm_allow` low forces CCM and clears the run. No number of such strobes can enter DCM.
- R8: `force_ccm` high at any clock edge sets `mode_dcm` to 0 and clears the run on that edge, with or without a strobe.
- R9: `thr_sel` follows `ocp_level` one clock later. The mapping is:
  - `ocp_level` 0 (9 A) gives 2'b11 (-440 mA);
  - `ocp_level` 1 (6 A) gives 2'b10 (-310 mA);
  - `ocp_level` 2 (4.5 A) gives 2'b01 (-220 mA);
  - `ocp_level` 3 (reserved) gives 2'b01.
  After reset, `thr_sel` is 2'b11.
- R10: Apart from `force_ccm` and reset, `mode_dcm` changes only on an edge that samples `cyc_stb` high.
- R11: In DCM, strobes with `above_exit` low keep `mode_dcm` at 1, whatever `below_entry` is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_stb | input | 1 | One-clock strobe per switching period |
| below_entry | input | 1 | Valley current was under the entry level this period |
| above_exit | input | 1 | Valley current was over the exit level this period |
| dcm_allow | input | 1 | Static configuration: DCM permitted |
| force_ccm | input | 1 | Hold CCM and clear the run (switching off or soft-start) |
| ocp_level | input | 2 | Overcurrent setting: 0 = 9 A, 1 = 6 A, 2 = 4.5 A, 3 = reserved |
| mode_dcm | output | 1 | 1 = discontinuous mode, 0 = continuous mode |
| thr_sel | output | 2 | Entry level select for the valley comparator |

## Verification
The stimulus uses runs of 47 and 48 qualifying strobes. The 47 versus 48 pair pins the entry point exactly.

A run broken by one non-qualifying strobe, and a run padded with strobe-less clock edges, separate two behaviours: a run that restarts and a run that only pauses. Exit is tried with and without a strobe, and with `below_entry` still high, so that a strobed exit is not confused with a level-sensitive one.

Disallowed strobes, `force_ccm` pulses and a mid-DCM reset are each followed by a fresh 47-strobe run. That run shows whether the count was truly cleared or only masked.

// File: rtl/dcm_ctrl_pkg.sv
package dcm_ctrl_pkg;

    typedef enum logic {
        MODE_CCM = 1'b0,
        MODE_DCM = 1'b1
    } cond_mode_e;

    localparam logic [1:0] THR_NEG440 = 2'b11;
    localparam logic [1:0] THR_NEG310 = 2'b10;
    localparam logic [1:0] THR_NEG220 = 2'b01;

    // Overcurrent setting to entry-level code; the reserved setting takes the smallest magnitude.
    function automatic logic [1:0] ocp_to_thr(input logic [1:0] level);
        case (level)
            2'd0:    return THR_NEG440;
            2'd1:    return THR_NEG310;
            default: return THR_NEG220;
        endcase
    endfunction

endpackage

// File: rtl/dcm_run_counter.sv
module dcm_run_counter #(
    parameter int LIMIT = 48,
    localparam int W = $clog2(LIMIT + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         clr,
    output logic [W-1:0] count,
    output logic         last
);

    typedef struct packed {
        logic [W-1:0] count;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.count = '0;
        end else if (inc && st_q.count != W'(LIMIT)) begin
            st_d.count = st_q.count + W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.count;
    assign last  = (st_q.count == W'(LIMIT - 1));

    // R6: saturation bound
    assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.count <= W'(LIMIT));

    // R6: a clear request empties the run
    assert_clear_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (st_q.count == '0));

    // R2: each qualifying period below the limit adds exactly one
    assert_step_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr && st_q.count != W'(LIMIT)) |=> (st_q.count == $past(st_q.count) + W'(1)));

endmodule

// File: rtl/dcm_thr_map.sv
module dcm_thr_map
    import dcm_ctrl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] ocp_level,
    output logic [1:0] thr_sel
);

    typedef struct packed {
        logic [1:0] code;
    } thr_state_t;

    thr_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.code = ocp_to_thr(ocp_level);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{code: THR_NEG440};
        else        st_q <= st_d;
    end

    assign thr_sel = st_q.code;

    // R9: the 9 A setting selects the deepest entry level
    assert_thr_9a_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ocp_level == 2'd0) |=> (thr_sel == 2'b11));

    // R9: the 6 A setting selects the middle entry level
    assert_thr_6a_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ocp_level == 2'd1) |=> (thr_sel == 2'b10));

    // R9: the all-zero code is never produced
    assert_thr_nonzero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        thr_sel != 2'b00);

endmodule

// File: rtl/dcm_mode_fsm.sv
module dcm_mode_fsm
    import dcm_ctrl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_stb,
    input  logic below_entry,
    input  logic above_exit,
    input  logic dcm_allow,
    input  logic force_ccm,
    input  logic cnt_last,
    output logic cnt_inc,
    output logic cnt_clr,
    output logic mode_dcm
);

    typedef struct packed {
        cond_mode_e mode;
    } fsm_state_t;

    fsm_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        cnt_inc = 1'b0;
        cnt_clr = 1'b0;
        if (force_ccm) begin
            st_d.mode = MODE_CCM;
            cnt_clr   = 1'b1;
        end else if (cyc_stb) begin
            if (!dcm_allow) begin
                st_d.mode = MODE_CCM;
                cnt_clr   = 1'b1;
            end else if (st_q.mode == MODE_CCM) begin
                if (below_entry) begin
                    cnt_inc = 1'b1;
                    if (cnt_last) st_d.mode = MODE_DCM;
                end else begin
                    cnt_clr = 1'b1;
                end
            end else begin
                if (above_exit) begin
                    st_d.mode = MODE_CCM;
                    cnt_clr   = 1'b1;
                end else if (below_entry) begin
                    cnt_inc = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{mode: MODE_CCM};
        else        st_q <= st_d;
    end

    assign mode_dcm = (st_q.mode == MODE_DCM);

    // R10: mode is frozen between strobes unless forced
    assert_hold_between_strobes_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!cyc_stb && !force_ccm) |=> $stable(mode_dcm));

    // R5: one strobed exit period leaves DCM
    assert_exit_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_stb && !force_ccm && mode_dcm && above_exit) |=> !mode_dcm);

    // R7: a disallowed strobe lands in CCM
    assert_barred_ccm_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_stb && !dcm_allow) |=> !mode_dcm);

    // R8: force holds CCM
    assert_force_ccm_R8: assert property (@(posedge clk) disable iff (!rst_n)
        force_ccm |=> !mode_dcm);

    // R2: entry only on the strobe completing the run
    assert_entry_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode_dcm) |-> $past(cyc_stb && below_entry && dcm_allow && cnt_last));

    // R11: DCM kept while no exit period is seen
    assert_dcm_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_dcm && cyc_stb && dcm_allow && !above_exit && !force_ccm) |=> mode_dcm);

endmodule

// File: rtl/dcm_mode_ctrl.sv
module dcm_mode_ctrl #(
    parameter int ENTRY_CYCLES = 48
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cyc_stb,
    input  logic       below_entry,
    input  logic       above_exit,
    input  logic       dcm_allow,
    input  logic       force_ccm,
    input  logic [1:0] ocp_level,
    output logic       mode_dcm,
    output logic [1:0] thr_sel
);

    localparam int CNT_W = $clog2(ENTRY_CYCLES + 1);

    logic             cnt_inc;
    logic             cnt_clr;
    logic             cnt_last;
    logic [CNT_W-1:0] run_cnt;

    dcm_run_counter #(
        .LIMIT (ENTRY_CYCLES)
    ) i_run_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (cnt_inc),
        .clr   (cnt_clr),
        .count (run_cnt),
        .last  (cnt_last)
    );

    dcm_mode_fsm i_mode_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cyc_stb     (cyc_stb),
        .below_entry (below_entry),
        .above_exit  (above_exit),
        .dcm_allow   (dcm_allow),
        .force_ccm   (force_ccm),
        .cnt_last    (cnt_last),
        .cnt_inc     (cnt_inc),
        .cnt_clr     (cnt_clr),
        .mode_dcm    (mode_dcm)
    );

    dcm_thr_map i_thr_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .ocp_level (ocp_level),
        .thr_sel   (thr_sel)
    );

    // R8: force leaves CCM with an empty run
    assert_force_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        force_ccm |=> (!mode_dcm && run_cnt == '0));

    // R6: CCM re-entry from DCM empties the run
    assert_reentry_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mode_dcm) |-> (run_cnt == '0));

    // R1: DCM is only ever held with a complete run behind it
    assert_dcm_full_run_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mode_dcm |-> (run_cnt == CNT_W'(ENTRY_CYCLES)));

endmodule

// File: tb/test_dcm_mode_ctrl.sv
`timescale 1ns/1ps
module test_dcm_mode_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_stb = 1'b0;
    logic       below_entry = 1'b0;
    logic       above_exit = 1'b0;
    logic       dcm_allow = 1'b1;
    logic       force_ccm = 1'b0;
    logic [1:0] ocp_level = 2'd0;
    logic       mode_dcm;
    logic [1:0] thr_sel;

    int n_checks = 0;
    int n_fails  = 0;

    always #2.5 clk = ~clk;

    dcm_mode_ctrl i_dcm_mode_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cyc_stb     (cyc_stb),
        .below_entry (below_entry),
        .above_exit  (above_exit),
        .dcm_allow   (dcm_allow),
        .force_ccm   (force_ccm),
        .ocp_level   (ocp_level),
        .mode_dcm    (mode_dcm),
        .thr_sel     (thr_sel)
    );

    typedef struct packed {
        int reps;
        bit stb;
        bit below;
        bit above;
        bit allow;
        bit frc;
        bit exp_mode;
        int req;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{47, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 2},   // R2: 47 not enough
        '{1,  1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 2},   // R2: 48th enters
        '{5,  1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 11},  // R11: stay in DCM
        '{3,  1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 10},  // R10/R5: exit flag without strobe
        '{1,  1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 5},   // R5: strobed exit
        '{47, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 6},   // R6: run was cleared
        '{1,  1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 3},   // R3: break
        '{47, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 3},   // R3: restarted run
        '{1,  1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 3},   // R3: full run enters
        '{1,  1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 7},   // R7: disallowed strobe leaves DCM
        '{60, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 7},   // R7: never enters
        '{47, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 7},   // R7: run held at zero
        '{1,  1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8},   // R8: force clears
        '{47, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8},   // R8: run restarted
        '{1,  1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8},   // R8: enters
        '{1,  1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8},   // R8: force leaves DCM without strobe
        '{20, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4},   // R4: no strobe, no count
        '{48, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 4}    // R4: full strobed run enters
    };

    task automatic check_bit(input logic act, input logic exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: got %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic check_code(input logic [1:0] act, input logic [1:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        cyc_stb     = 1'b0;
        below_entry = 1'b0;
        above_exit  = 1'b0;
        force_ccm   = 1'b0;
        dcm_allow   = 1'b1;
    endtask

    task automatic run_strobes(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            cyc_stb     = 1'b1;
            below_entry = 1'b1;
        end
        @(negedge clk);
        idle_inputs();
    endtask

    initial begin
        #1000000;
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fails + 1, n_checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check_bit(mode_dcm, 1'b0, "R1 mode after reset");
        check_code(thr_sel, 2'b11, "R1 thr_sel after reset");
        rst_n = 1'b1;

        // table walk
        for (int v = 0; v < NV; v++) begin
            for (int k = 0; k < VECS[v].reps; k++) begin
                @(negedge clk);
                cyc_stb     = VECS[v].stb;
                below_entry = VECS[v].below;
                above_exit  = VECS[v].above;
                dcm_allow   = VECS[v].allow;
                force_ccm   = VECS[v].frc;
            end
            @(negedge clk);
            idle_inputs();
            check_bit(mode_dcm, VECS[v].exp_mode, $sformatf("R%0d vector %0d", VECS[v].req, v));
        end

        // R1: reset in the middle of DCM
        rst_n = 1'b0;
        @(negedge clk);
        check_bit(mode_dcm, 1'b0, "R1 reset from DCM");
        rst_n = 1'b1;
        run_strobes(47);
        check_bit(mode_dcm, 1'b0, "R1 run empty after reset");
        run_strobes(1);
        check_bit(mode_dcm, 1'b1, "R1 entry after full run");

        // R9: entry level mapping, one clock later
        for (int c = 0; c < 4; c++) begin
            logic [1:0] exp_code;
            exp_code = (c == 0) ? 2'b11 : (c == 1) ? 2'b10 : 2'b01;
            @(negedge clk);
            ocp_level = 2'(c);
            @(negedge clk);
            check_code(thr_sel, exp_code, $sformatf("R9 ocp_level %0d", c));
        end

        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule